// File: doc/BRIEF.md
# Port and Scratchpad Access Unit

This block carries out the data-movement instructions of a small 8-bit controller core: reading a byte from an external port, writing a byte to an external port, and writing to or reading from a 64-byte scratchpad. The core's sequencer gives it an operation code, the source register value, the address operand and a phase flag that marks the second clock of each two-clock instruction. The block drives the port address, the outgoing byte and the read and write strobes. It holds the scratchpad, and it returns the byte that goes back to the destination register.

Every access takes two clocks. The port address is driven for both clocks of a port access. A strobe is raised only in the second clock, and only when the clock before it was the first clock of the same operation. Scratchpad addresses use only their low six bits. The scratchpad has no reset, so its contents survive a reset of the core. Read results (port input or scratchpad fetch) are captured at the clock edge that ends the second clock. They are presented, with a one-clock valid pulse, in the clock after it.

Top module: `io_scratch_unit`

## Requirements
- R1: While reset is asserted and after it is released with an idle operation, `read_strobe`, `write_strobe` and `wb_valid` are 0 and `port_id` and `out_port` are 0.
- R2: For a port write (`op_sel` = 2), `port_id` equals `addr_opnd` and `out_port` equals `reg_sx` in both clocks, and `write_strobe` is 1 only in the second clock.
- R3: For a port read (`op_sel` = 1), `port_id` equals `addr_opnd` in both clocks and `read_strobe` is 1 only in the second clock. The value on `in_port` at the edge ending the second clock appears on `wb_data` with `wb_valid` = 1 in the following clock.
- R4: A store (`op_sel` = 3) writes `reg_sx` into the scratchpad at the edge ending its second clock. A later fetch (`op_sel` = 4) from the same address returns that byte on `wb_data` with `wb_valid` = 1 in the clock after the fetch's second clock.
- R5: Only `addr_opnd[5:0]` selects a scratchpad byte, so 0xFF and 0x3F name one location, as do 0x40 and 0x00.
- R6: During a store, a fetch or an idle clock (`op_sel` = 0, or the unused codes 5 to 7), both strobes are 0 and `port_id` and `out_port` are 0.
- R7: A clock with `phase_2nd` = 1 that does not follow a first clock of the same operation has no effect: no strobe, no scratchpad write and no `wb_valid`.
- R8: Reset does not change the scratchpad contents.
- R9: `read_strobe` and `write_strobe` are never 1 together, and neither is 1 for two clocks in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, already synchronised for release |
| op_sel | input | 3 | 0 idle, 1 port read, 2 port write, 3 store, 4 fetch, 5 to 7 idle |
| phase_2nd | input | 1 | High in the second clock of the instruction |
| reg_sx | input | 8 | Source register value |
| addr_opnd | input | 8 | Port address or scratchpad address operand |
| in_port | input | 8 | Byte from the external port |
| port_id | output | 8 | Port address during port accesses, else 0 |
| out_port | output | 8 | Outgoing byte during port writes, else 0 |
| read_strobe | output | 1 | Port read strobe, second clock only |
| write_strobe | output | 1 | Port write strobe, second clock only |
| wb_data | output | 8 | Byte for register writeback |
| wb_valid | output | 1 | One-clock pulse marking `wb_data` valid |

## Verification
The port address, the outgoing byte and both strobes are combinational outputs of the current clock and its registered phase history. They are checked between clock edges in the same clock in which their inputs are driven, once in the first clock and once in the second. Writeback values pass through one register, so each is due exactly one clock after the second clock of its port read or fetch. The driver queues the expected byte before that edge, and a monitor pops it at the next falling edge whenever `wb_valid` is high. A pulse that arrives with nothing queued, or a byte left in the queue at the end, counts as a failure.

// File: rtl/io_scratch_pkg.sv
package io_scratch_pkg;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [2:0] {
    ACC_IDLE  = 3'd0,
    ACC_PIN   = 3'd1,
    ACC_POUT  = 3'd2,
    ACC_STORE = 3'd3,
    ACC_FETCH = 3'd4
  } acc_op_e;

  function automatic acc_op_e decode_op(input logic [2:0] code);
    case (code)
      3'd1:    return ACC_PIN;
      3'd2:    return ACC_POUT;
      3'd3:    return ACC_STORE;
      3'd4:    return ACC_FETCH;
      default: return ACC_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/io_phase_track.sv
module io_phase_track
  import io_scratch_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  acc_op_e op,
  input  logic    phase_2nd,
  output logic    commit
);
  logic    first_q, first_d;
  acc_op_e op_q, op_d;

  always_comb begin
    first_d = (op != ACC_IDLE) && !phase_2nd;
    op_d    = op;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b0;
      op_q    <= ACC_IDLE;
    end else begin
      first_q <= first_d;
      op_q    <= op_d;
    end
  end

  assign commit = phase_2nd && first_q && (op_q == op) && (op != ACC_IDLE);

  // R7: a commit is only possible one clock after a first-phase clock
  assert_commit_after_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> ($past(!phase_2nd) && ($past(op) == op)));
endmodule

// File: rtl/io_port_drv.sv
module io_port_drv
  import io_scratch_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  acc_op_e       op,
  input  logic          commit,
  input  logic [DW-1:0] sx,
  input  logic [DW-1:0] addr,
  output logic [DW-1:0] port_id,
  output logic [DW-1:0] out_port,
  output logic          rd_stb,
  output logic          wr_stb
);
  logic port_acc;

  always_comb begin
    port_acc = (op == ACC_PIN) || (op == ACC_POUT);
    port_id  = port_acc ? addr : '0;
    out_port = (op == ACC_POUT) ? sx : '0;
    rd_stb   = commit && (op == ACC_PIN);
    wr_stb   = commit && (op == ACC_POUT);
  end

  assert_strobe_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && wr_stb));
  assert_wr_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  assert_rd_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> !rd_stb);
  // R2: the address seen by the port decoder is held across both clocks
  assert_wr_addr_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $stable(port_id));
endmodule

// File: rtl/io_scratch_ram.sv
module io_scratch_ram
  import io_scratch_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [DW-1:0] addr_full,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [AW-1:0] idx;
  logic [DW-1:0] mem [DEPTH];

  assign idx = addr_full[AW-1:0];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[idx] <= wdata;
    end
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/io_wb_capture.sv
module io_wb_capture
  import io_scratch_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic          sel_port,
  input  logic [DW-1:0] port_val,
  input  logic [DW-1:0] ram_val,
  output logic [DW-1:0] wb_data,
  output logic          wb_valid
);
  logic [DW-1:0] data_q, data_d;
  logic          vld_q, vld_d;

  always_comb begin
    vld_d  = cap_en;
    data_d = sel_port ? port_val : ram_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (cap_en) begin
        data_q <= data_d;
      end
    end
  end

  assign wb_data  = data_q;
  assign wb_valid = vld_q;
endmodule

// File: rtl/io_scratch_unit.sv
module io_scratch_unit
  import io_scratch_pkg::*;
#(
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned RAMAW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    op_sel,
  input  logic          phase_2nd,
  input  logic [DW-1:0] reg_sx,
  input  logic [DW-1:0] addr_opnd,
  input  logic [DW-1:0] in_port,
  output logic [DW-1:0] port_id,
  output logic [DW-1:0] out_port,
  output logic          read_strobe,
  output logic          write_strobe,
  output logic [DW-1:0] wb_data,
  output logic          wb_valid
);
  acc_op_e       op;
  logic          commit;
  logic          ram_we;
  logic          cap_en;
  logic [DW-1:0] ram_rd;

  assign op     = decode_op(op_sel);
  assign ram_we = commit && (op == ACC_STORE);
  assign cap_en = commit && ((op == ACC_PIN) || (op == ACC_FETCH));

  io_phase_track u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .phase_2nd (phase_2nd),
    .commit    (commit)
  );

  io_port_drv #(.DW(DW)) u_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .commit   (commit),
    .sx       (reg_sx),
    .addr     (addr_opnd),
    .port_id  (port_id),
    .out_port (out_port),
    .rd_stb   (read_strobe),
    .wr_stb   (write_strobe)
  );

  io_scratch_ram #(.DW(DW), .AW(RAMAW)) u_ram (
    .clk       (clk),
    .we        (ram_we),
    .addr_full (addr_opnd),
    .wdata     (reg_sx),
    .rdata     (ram_rd)
  );

  io_wb_capture #(.DW(DW)) u_wb (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .sel_port (op == ACC_PIN),
    .port_val (in_port),
    .ram_val  (ram_rd),
    .wb_data  (wb_data),
    .wb_valid (wb_valid)
  );

  // R3/R4: every writeback pulse follows a read strobe or a fetch second clock
  assert_wb_has_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> ($past(read_strobe) || ($past(op) == ACC_FETCH && $past(phase_2nd))));
  // R6: strobes only ever appear in a second clock
  assert_strobe_in_phase2_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (read_strobe || write_strobe) |-> phase_2nd);
endmodule

// File: tb/io_scratch_unit_bench.sv
module io_scratch_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] op_sel;
  logic       phase_2nd;
  logic [7:0] reg_sx, addr_opnd, in_port;
  logic [7:0] port_id, out_port, wb_data;
  logic       read_strobe, write_strobe, wb_valid;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  io_scratch_unit u_io_scratch_unit (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .phase_2nd(phase_2nd),
    .reg_sx(reg_sx), .addr_opnd(addr_opnd), .in_port(in_port),
    .port_id(port_id), .out_port(out_port), .read_strobe(read_strobe),
    .write_strobe(write_strobe), .wb_data(wb_data), .wb_valid(wb_valid)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // monitor: pops expected writeback bytes
  always @(negedge clk) begin
    if (rst_n === 1'b1 && wb_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3/R4 unexpected wb_valid", wb_data, 8'h00);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(wb_data === e, t, wb_data, e);
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    op_sel = 3'd0; phase_2nd = 1'b0; reg_sx = 8'h00; addr_opnd = 8'h00;
  endtask

  // two-clock access; expected wb pushed before the capturing edge
  task automatic do_op(input logic [2:0] op, input logic [7:0] sx, input logic [7:0] a,
                       input logic [7:0] in2, input logic [7:0] exp_wb, input string req);
    @(negedge clk);
    op_sel = op; phase_2nd = 1'b0; reg_sx = sx; addr_opnd = a; in_port = 8'hC3;
    #1;
    if (op == 3'd1 || op == 3'd2) begin
      chk(port_id === a, {req, " port_id clock1"}, port_id, a);
    end else begin
      chk(port_id === 8'h00 && out_port === 8'h00, "R6 ports quiet clock1", port_id, 8'h00);
    end
    if (op == 3'd2) chk(out_port === sx, "R2 out_port clock1", out_port, sx);
    chk({read_strobe, write_strobe} === 2'b00, {req, " strobes low clock1"},
        {6'd0, read_strobe, write_strobe}, 8'h00);
    @(negedge clk);
    phase_2nd = 1'b1; in_port = in2;
    #1;
    if (op == 3'd1 || op == 3'd2) chk(port_id === a, {req, " port_id clock2"}, port_id, a);
    if (op == 3'd2) chk(out_port === sx, "R2 out_port clock2", out_port, sx);
    chk(read_strobe === (op == 3'd1), {req, " read_strobe clock2"}, {7'd0, read_strobe}, {7'd0, op == 3'd1});
    chk(write_strobe === (op == 3'd2), {req, " write_strobe clock2"}, {7'd0, write_strobe}, {7'd0, op == 3'd2});
    chk(!(read_strobe && write_strobe), "R9 exclusive strobes", {6'd0, read_strobe, write_strobe}, 8'h00);
    if (op == 3'd1 || op == 3'd4) begin
      exp_q.push_back(exp_wb);
      tag_q.push_back({req, " wb_data"});
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=00 expected=01");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_sel = 3'd0; phase_2nd = 1'b0;
    reg_sx = 8'h00; addr_opnd = 8'h00; in_port = 8'h00;
    repeat (3) @(negedge clk);
    #1;
    chk({read_strobe, write_strobe, wb_valid} === 3'b000, "R1 reset outputs",
        {5'd0, read_strobe, write_strobe, wb_valid}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk(port_id === 8'h00 && out_port === 8'h00 && wb_valid === 1'b0, "R1 idle after reset",
        port_id, 8'h00);

    // port writes
    do_op(3'd2, 8'hA5, 8'h3C, 8'h00, 8'h00, "R2");
    idle(); #1;
    chk(write_strobe === 1'b0, "R9 write_strobe one clock", {7'd0, write_strobe}, 8'h00);
    do_op(3'd2, 8'h00, 8'hFF, 8'h00, 8'h00, "R2");
    do_op(3'd2, 8'hFF, 8'h00, 8'h00, 8'h00, "R2");

    // port reads, in_port changed in second clock
    do_op(3'd1, 8'h00, 8'h81, 8'h5A, 8'h5A, "R3");
    do_op(3'd1, 8'h12, 8'h07, 8'hE1, 8'hE1, "R3");
    idle(); #1;
    chk(read_strobe === 1'b0, "R9 read_strobe one clock", {7'd0, read_strobe}, 8'h00);

    // scratchpad
    do_op(3'd3, 8'h11, 8'h05, 8'h00, 8'h00, "R4");
    do_op(3'd3, 8'h22, 8'h3F, 8'h00, 8'h00, "R4");
    do_op(3'd4, 8'h00, 8'h05, 8'h00, 8'h11, "R4");
    do_op(3'd4, 8'h00, 8'hFF, 8'h00, 8'h22, "R5 alias FF");
    do_op(3'd3, 8'h33, 8'h40, 8'h00, 8'h00, "R5");
    do_op(3'd4, 8'h00, 8'h00, 8'h00, 8'h33, "R5 alias 40");

    // unused op code idles
    @(negedge clk);
    op_sel = 3'd6; phase_2nd = 1'b0; addr_opnd = 8'h44; reg_sx = 8'h99;
    @(negedge clk); phase_2nd = 1'b1; #1;
    chk(port_id === 8'h00 && {read_strobe, write_strobe} === 2'b00, "R6 unused code", port_id, 8'h00);

    // lone second clocks
    idle();
    @(negedge clk);
    op_sel = 3'd3; phase_2nd = 1'b1; reg_sx = 8'hAA; addr_opnd = 8'h05;
    idle();
    @(negedge clk);
    op_sel = 3'd2; phase_2nd = 1'b1; reg_sx = 8'h55; addr_opnd = 8'h10; #1;
    chk(write_strobe === 1'b0, "R7 lone second clock write", {7'd0, write_strobe}, 8'h00);
    idle();
    @(negedge clk);
    op_sel = 3'd4; phase_2nd = 1'b1; addr_opnd = 8'h05;
    idle(); idle(); #1;
    chk(wb_valid === 1'b0, "R7 lone fetch no wb", {7'd0, wb_valid}, 8'h00);
    do_op(3'd4, 8'h00, 8'h05, 8'h00, 8'h11, "R7 store ignored");

    // reset keeps scratchpad
    idle();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); #1;
    chk(wb_valid === 1'b0, "R1 wb_valid in reset", {7'd0, wb_valid}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    do_op(3'd4, 8'h00, 8'h3F, 8'h00, 8'h22, "R8");
    idle(); idle(); idle();
    chk(exp_q.size() == 0, "R3/R4 queue drained", 8'(exp_q.size()), 8'h00);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule